// File: doc/BRIEF.md
# Oversampled RMII Receiver

This block takes in Ethernet frames from an RMII PHY whose 50 MHz reference clock does not drive the block. Instead, the reference clock, the two receive data bits and the carrier/data-valid line all pass through two-flop synchronizers into the faster local clock. A rising edge of the synchronized reference clock marks the moment one dibit is taken. The receiver discards the zero dibits that can come before the preamble. It then hunts through the preamble for the final `11` dibit of the start delimiter, and from that point packs the data dibits into bytes.

Each byte comes out as a one-cycle strobe, with a start flag on the first byte. The CRC-32 is updated as each byte completes. When the frame ends, a one-cycle end strobe carries the byte count and a good/bad verdict. The byte count includes the 4-byte FCS. If the reference clock stops in the middle of a frame, the frame is closed and reported as bad.

The block is meant to sit next to a MAC that runs on its own system clock. That clock must run at least about 2.5 times the reference rate. The design target is five local clocks per reference cycle.

Top module: `rmii_os_rx`

## Requirements
- R1: After reset, `out_valid`, `out_sof`, `out_eof`, `out_good` and `out_len` are all zero.
- R2: While carrier is high, leading `00` dibits are discarded, and no preamble or delimiter bits are output. The first output byte is built from the first four data dibits that follow the `11` dibit ending the delimiter (delimiter byte 0xD5, preamble bytes 0x55).
- R3: Dibits are packed least significant first, and RXD[0] is the earlier bit. The k-th data dibit of a byte (k = 0..3) lands in bits [2k+1:2k].
- R4: Each completed byte gives `out_valid` high for exactly one local clock, with `out_data` holding the byte. `out_sof` is high together with the first byte of a frame only.
- R5: A data-phase dibit with CRS_DV low is dropped. Two consecutive such dibits end the frame, and `out_eof` pulses for one clock, never in the same cycle as `out_valid`. `out_len` is set to the number of bytes output, and it changes only with `out_eof`.
- R6: The CRC register starts at all ones. It runs the reflected polynomial 0x04C11DB7 over every byte after the delimiter, FCS included. `out_good` is 1 at `out_eof` only when three conditions hold: the register equals 0xDEBB20E3, no partial byte is pending, and at least 4 bytes arrived.
- R7: Reception is correct for reference duty cycles of both 40/60 and 60/40 at five local clocks per reference cycle.
- R8: If no reference rising edge is seen for `STALL_LIM` local clocks while in the data phase, the block emits `out_eof` with `out_good` = 0 and the byte count so far. The next frame is then received normally.
- R9: While idle, dibits that have CRS_DV low are ignored, whatever the value of RXD: no byte and no end strobe appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk_i | input | 1 | RMII 50 MHz reference clock, sampled as data |
| rxd_i | input | 2 | RMII receive dibit |
| crs_dv_i | input | 1 | RMII carrier sense / data valid |
| out_data | output | 8 | Received byte |
| out_valid | output | 1 | One-clock strobe for `out_data` |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | One-clock end-of-frame strobe |
| out_good | output | 1 | Frame verdict, valid at `out_eof` |
| out_len | output | LEN_W | Byte count of the last frame, FCS included |

## Verification
The assertions check, on every cycle, the framing of the output strobes: byte and end strobes each last one clock, the start flag appears only with a byte, the end strobe never coincides with a byte, the length moves only at an end strobe, and a good verdict never comes with fewer than four bytes. Whether the bytes are the right bytes can only be shown by the bench's scenarios. These cover delimiter alignment, bit order, the CRC verdict, the dropping of single low CRS_DV dibits, both duty-cycle extremes, the stall abort with recovery, a trailing partial byte and idle noise.

// File: rtl/rmii_os_rx.sv
module rmii_os_rx #(
  parameter int          STALL_LIM = 16,
  parameter int          LEN_W     = 16,
  parameter logic [31:0] CRC_RES   = 32'hDEBB20E3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_clk_i,
  input  logic [1:0]       rxd_i,
  input  logic             crs_dv_i,
  output logic [7:0]       out_data,
  output logic             out_valid,
  output logic             out_sof,
  output logic             out_eof,
  output logic             out_good,
  output logic [LEN_W-1:0] out_len
);

  localparam int SW = $clog2(STALL_LIM + 1);

  typedef enum logic [1:0] {S_IDLE, S_HUNT, S_DATA} st_t;

  logic [1:0] ref_q, crs_q, rxd_a, rxd_b;
  logic       ref_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ref_q <= '0; crs_q <= '0; rxd_a <= '0; rxd_b <= '0; ref_d <= 1'b0;
    end else begin
      ref_q <= {ref_q[0], ref_clk_i};
      crs_q <= {crs_q[0], crs_dv_i};
      rxd_a <= rxd_i;
      rxd_b <= rxd_a;
      ref_d <= ref_q[1];
    end

  wire       rise = ref_q[1] & ~ref_d;
  wire [1:0] dib  = rxd_b;
  wire       dv   = crs_q[1];

  st_t              st;
  logic             lowprev, first;
  logic [1:0]       dcnt;
  logic [5:0]       sh;
  logic [31:0]      crc;
  logic [LEN_W-1:0] nbytes;
  logic [SW-1:0]    scnt;

  wire       stall    = (scnt == SW'(STALL_LIM));
  wire [7:0] byte_nxt = {dib, sh};

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++)
      r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  scnt <= '0;
    else if (rise || st == S_IDLE) scnt <= '0;
    else if (!stall)             scnt <= scnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; lowprev <= 1'b0; first <= 1'b0; dcnt <= '0; sh <= '0;
      crc <= '1; nbytes <= '0;
      out_data <= '0; out_valid <= 1'b0; out_sof <= 1'b0; out_eof <= 1'b0;
      out_good <= 1'b0; out_len <= '0;
    end else begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      if (st == S_DATA && stall) begin
        out_eof  <= 1'b1;
        out_good <= 1'b0;
        out_len  <= nbytes;
        st       <= S_IDLE;
      end else if (st == S_HUNT && stall) begin
        st <= S_IDLE;
      end else if (rise) begin
        case (st)
          S_IDLE: begin
            lowprev <= 1'b0; first <= 1'b1; dcnt <= '0; crc <= '1; nbytes <= '0;
            if (dv && dib != 2'b00)
              st <= (dib == 2'b11) ? S_DATA : S_HUNT;
          end
          S_HUNT: begin
            if (!dv) begin
              lowprev <= 1'b1;
              if (lowprev) st <= S_IDLE;
            end else begin
              lowprev <= 1'b0;
              if (dib == 2'b11) st <= S_DATA;
            end
          end
          S_DATA: begin
            if (!dv) begin
              lowprev <= 1'b1;
              if (lowprev) begin
                out_eof  <= 1'b1;
                out_good <= (crc == CRC_RES) && (dcnt == 2'd0) && (nbytes >= LEN_W'(4));
                out_len  <= nbytes;
                st       <= S_IDLE;
              end
            end else begin
              lowprev <= 1'b0;
              dcnt    <= dcnt + 1'b1;
              sh      <= {dib, sh[5:2]};
              if (dcnt == 2'd3) begin
                out_data  <= byte_nxt;
                out_valid <= 1'b1;
                out_sof   <= first;
                first     <= 1'b0;
                crc       <= crc_byte(crc, byte_nxt);
                nbytes    <= nbytes + 1'b1;
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end

endmodule

// File: rtl/rmii_os_rx_chk.sv
module rmii_os_rx_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_sof,
  input logic             out_eof,
  input logic             out_good,
  input logic [LEN_W-1:0] out_len
);

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R4
  sof_with_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);

  // R5
  eof_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |=> !out_eof);

  // R5
  eof_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> !out_valid);

  // R5
  len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_eof |-> out_len == $past(out_len));

  // R6
  good_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_eof && out_good) |-> out_len >= LEN_W'(4));

endmodule

bind rmii_os_rx rmii_os_rx_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_sof(out_sof),
  .out_eof(out_eof), .out_good(out_good), .out_len(out_len)
);

// File: tb/sim_rmii_os_rx.sv
module sim_rmii_os_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_clk = 1'b0;
  logic [1:0]  rxd = 2'b00;
  logic        crs_dv = 1'b0;
  logic [7:0]  out_data;
  logic        out_valid, out_sof, out_eof, out_good;
  logic [15:0] out_len;

  rmii_os_rx u0 (
    .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk), .rxd_i(rxd), .crs_dv_i(crs_dv),
    .out_data(out_data), .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
    .out_good(out_good), .out_len(out_len)
  );

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  int hi = 2, lo = 3;

  logic [7:0] got [0:127];
  int got_n = 0, sof_at = -1, sof_n = 0, eof_n = 0, eof_len = 0;
  bit eof_good = 1'b0;

  logic [7:0] fr [0:127];
  int fr_n = 0;

  always @(negedge clk) if (rst_n) begin
    if (out_valid) begin
      if (got_n < 128) got[got_n] = out_data;
      if (out_sof) begin sof_at = got_n; sof_n++; end
      got_n++;
    end
    if (out_eof) begin eof_n++; eof_len = int'(out_len); eof_good = out_good; end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    got_n = 0; sof_at = -1; sof_n = 0; eof_n = 0; eof_len = 0; eof_good = 1'b0;
  endtask

  task automatic dib(input logic [1:0] d, input logic c);
    ref_clk = 1'b0; rxd = d; crs_dv = c;
    repeat (lo) @(negedge clk);
    ref_clk = 1'b1;
    repeat (hi) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit tog);
    for (int k = 0; k < 4; k++) begin
      dib(b[2*k +: 2], 1'b1);
      if (tog) dib(2'b10, 1'b0);
    end
  endtask

  function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = ((r[0] ^ b[i]) != 1'b0) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic build(input int n, input int seed, input bit corrupt);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      fr[i] = 8'((i * 37 + seed) & 8'hFF);
      c = crc_upd(c, fr[i]);
    end
    c = ~c;
    for (int i = 0; i < 4; i++) fr[n + i] = c[8*i +: 8];
    fr_n = n + 4;
    if (corrupt) fr[2] = fr[2] ^ 8'h10;
  endtask

  task automatic send_frame(input int lead0, input int tog_from, input int extra);
    for (int i = 0; i < lead0; i++) dib(2'b00, 1'b1);
    for (int i = 0; i < 7; i++) send_byte(8'h55, 1'b0);
    send_byte(8'hD5, 1'b0);
    for (int i = 0; i < fr_n; i++) send_byte(fr[i], i >= tog_from);
    for (int i = 0; i < extra; i++) dib(2'b01, 1'b1);
    dib(2'b00, 1'b0); dib(2'b00, 1'b0);
    for (int i = 0; i < 3; i++) dib(2'b00, 1'b0);
  endtask

  task automatic check_bytes(input string req);
    bit same;
    same = (got_n == fr_n);
    for (int i = 0; i < fr_n && i < got_n; i++) if (got[i] != fr[i]) same = 1'b0;
    chk(same, req, "byte stream match (count)", got_n, fr_n);
    chk(sof_at == 0 && sof_n == 1, "R4", "start flag index", sof_at, 0);
    chk(eof_n == 1, "R5", "end strobes", eof_n, 1);
    chk(eof_len == fr_n, "R5", "frame length", eof_len, fr_n);
  endtask

  task automatic t_reset();
    chk(out_valid == 0 && out_sof == 0 && out_eof == 0, "R1", "strobes after reset",
        int'({out_valid, out_sof, out_eof}), 0);
    chk(out_good == 0 && out_len == 0, "R1", "good/len after reset", int'(out_len), 0);
  endtask

  task automatic t_good();
    clear_mon(); hi = 2; lo = 3;
    build(12, 8'h1B, 1'b0);
    send_frame(5, 999, 0);
    check_bytes("R2");
    chk(got[0] == 8'h1B, "R3", "first byte packing", int'(got[0]), 8'h1B);
    chk(eof_good == 1'b1, "R6", "good verdict", int'(eof_good), 1);
  endtask

  task automatic t_badcrc();
    clear_mon(); hi = 2; lo = 3;
    build(10, 5, 1'b1);
    send_frame(0, 999, 0);
    check_bytes("R6");
    chk(eof_good == 1'b0, "R6", "corrupted frame verdict", int'(eof_good), 0);
  endtask

  task automatic t_duty();
    clear_mon(); hi = 3; lo = 2;
    build(20, 99, 1'b0);
    send_frame(2, 999, 0);
    check_bytes("R7");
    chk(eof_good == 1'b1, "R7", "60/40 duty verdict", int'(eof_good), 1);
    hi = 2; lo = 3;
  endtask

  task automatic t_toggle();
    clear_mon(); hi = 2; lo = 3;
    build(8, 3, 1'b0);
    send_frame(0, 10, 0);
    check_bytes("R5");
    chk(eof_good == 1'b1, "R5", "toggling carrier verdict", int'(eof_good), 1);
  endtask

  task automatic t_stall();
    clear_mon(); hi = 2; lo = 3;
    for (int i = 0; i < 7; i++) send_byte(8'h55, 1'b0);
    send_byte(8'hD5, 1'b0);
    send_byte(8'hA1, 1'b0); send_byte(8'hB2, 1'b0); send_byte(8'hC3, 1'b0);
    ref_clk = 1'b0;
    repeat (40) @(negedge clk);
    chk(eof_n == 1, "R8", "abort end strobe", eof_n, 1);
    chk(eof_good == 1'b0, "R8", "abort verdict", int'(eof_good), 0);
    chk(eof_len == 3, "R8", "abort length", eof_len, 3);
    dib(2'b00, 1'b0); dib(2'b00, 1'b0);
    clear_mon();
    build(6, 77, 1'b0);
    send_frame(1, 999, 0);
    chk(eof_n == 1 && eof_good == 1'b1, "R8", "frame after abort good", int'(eof_good), 1);
  endtask

  task automatic t_partial();
    clear_mon(); hi = 2; lo = 3;
    build(9, 44, 1'b0);
    send_frame(0, 999, 1);
    chk(eof_good == 1'b0, "R6", "partial byte verdict", int'(eof_good), 0);
    chk(eof_len == fr_n, "R6", "partial byte length", eof_len, fr_n);
  endtask

  task automatic t_idle();
    clear_mon(); hi = 2; lo = 3;
    for (int i = 0; i < 24; i++) dib(2'(i % 4), 1'b0);
    repeat (10) @(negedge clk);
    chk(got_n == 0, "R9", "bytes while idle", got_n, 0);
    chk(eof_n == 0, "R9", "end strobes while idle", eof_n, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_good();
    t_badcrc();
    t_duty();
    t_toggle();
    t_stall();
    t_partial();
    t_idle();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule